// File: doc/BRIEF.md
# Banked System Control Register

This block holds a 32-bit system control word in two independent copies, one for the Secure state and one for the Non-secure state. Each access goes to the copy named by the security-state input. The block checks the current privilege level and rejects any access from the unprivileged level. It forces the reserved and read-only bit positions to fixed values. While a lock pin is high, it ignores writes to the Secure copy.

Software reaches the register through a simple strobe port: a read strobe, a write strobe and a write-data bus. Read data is combinational. A write takes effect at the next clock edge. The active copy, after masking, is always driven onto a control-word output. The four most commonly used enables are also brought out as separate pins, so the cache, translation and alignment logic can read them directly.

Three configuration pins set the reset value of three Secure-copy fields: the exception instruction-set select, the exception endianness and the high-vector select. These pins are sampled only while reset is held.

Top module: `sysctl_banked_reg`

## Requirements
- R1: Each security state has its own copy of the register. `sec_state`=1 selects the Secure copy and `sec_state`=0 selects the Non-secure copy. A write to one copy never changes the other.
- R2: An access with `priv_lvl`=0 is rejected. In the same cycle it raises `acc_fault`, returns `acc_rdata`=0, and changes neither copy.
- R3: When `priv_lvl` is 1, 2 or 3, the selected copy can be read and written. A write becomes visible in the cycle after the write strobe. `acc_rdata` is zero whenever no permitted read is in progress.
- R4: While `sec_wr_lock`=1, writes to the Secure copy are dropped and raise no fault. Reads of the Secure copy and all accesses to the Non-secure copy work as usual.
- R5: The following bits always read 0 and ignore writes: 31, 27:26, 24, 21, 17, 15:14, 10:9 and the read-only bit 6. Bits 23:22, 11 and 4:3 always read 1.
- R6: After reset, bits 18, 16 and 5 are 1 and all other writable bits are 0 in both copies. The exception: Secure bits 30, 25 and 13 take the values of `cfg_exc_isa`, `cfg_exc_be` and `cfg_hivec` as they stand during reset. Changing these pins after reset has no effect.
- R7: While `long_desc`=1, bits 29 and 28 read as 1. The stored values of those bits are kept.
- R8: `ctl_word` shows the active copy with the R5 and R7 masks applied. `mmu_en`, `align_chk_en`, `dcache_en` and `icache_en` equal bits 0, 1, 2 and 12 of `ctl_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Current privilege level, 0 = unprivileged |
| sec_state | input | 1 | 1 = Secure, 0 = Non-secure |
| sec_wr_lock | input | 1 | Blocks writes to the Secure copy |
| long_desc | input | 1 | Long-descriptor format select |
| cfg_exc_isa | input | 1 | Reset value of Secure bit 30 |
| cfg_exc_be | input | 1 | Reset value of Secure bit 25 |
| cfg_hivec | input | 1 | Reset value of Secure bit 13 |
| acc_rdata | output | 32 | Read data |
| acc_fault | output | 1 | Access rejected this cycle |
| ctl_word | output | 32 | Active copy after masking |
| mmu_en | output | 1 | Bit 0 of active copy |
| align_chk_en | output | 1 | Bit 1 of active copy |
| dcache_en | output | 1 | Bit 2 of active copy |
| icache_en | output | 1 | Bit 12 of active copy |

## Verification
The assertions assume three things about the inputs:
- Strobes come from the core's register-access sequencer, so a read and a write are never issued in the same cycle.
- `sec_state` and `priv_lvl` hold steady for the whole access cycle.
- The lock pin is never X.

The stimulus keeps to these assumptions: each table row drives at most one strobe and sets all control inputs on the falling edge. The state-hold properties compare the stored copies only across a single clock edge, so a change of `sec_state` between rows cannot trip them.

// File: rtl/sysctl_pkg.sv
// Package: shared widths, masks and reset constants for the banked control register.
// Assumes a 32-bit register; every mask below is written against that width.
package sysctl_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned PRIV_W  = 2;
    localparam int unsigned N_BANKS = 2;
    localparam int unsigned BANK_NS = 0;
    localparam int unsigned BANK_S  = 1;

    // bit positions whose meaning neighbours decode
    localparam int unsigned B_MMU    = 0;
    localparam int unsigned B_ALIGN  = 1;
    localparam int unsigned B_DCACHE = 2;
    localparam int unsigned B_ICACHE = 12;
    localparam int unsigned B_HIVEC  = 13;
    localparam int unsigned B_EXC_BE = 25;
    localparam int unsigned B_EXC_I  = 30;

    typedef logic [WORD_W-1:0] word_t;

    // bits held in flops
    localparam word_t WR_MASK   = 32'h721D_31A7;
    // bits that always read one
    localparam word_t FIX1_MASK = 32'h00C0_0818;
    // bits forced to one by the long-descriptor select
    localparam word_t LD_MASK   = 32'h3000_0000;
    // reset value common to both copies
    localparam word_t RST_BASE  = 32'h0005_0020;
endpackage

// File: rtl/sysctl_access_ctl.sv
// Access control: turns strobes, privilege, security state and the lock
// into a fault flag, a permitted-read flag and one write enable per copy.
// Assumes acc_rd and acc_wr are never high together.
module sysctl_access_ctl
    import sysctl_pkg::*;
(
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic              sec_state,
    input  logic              sec_wr_lock,
    output logic              fault,
    output logic              rd_ok,
    output logic [N_BANKS-1:0] wr_en
);
    logic permit;

    // decide permission and route the write strobe to one copy
    always_comb begin
        permit = (priv_lvl != '0);
        fault  = (acc_rd | acc_wr) & ~permit;
        rd_ok  = acc_rd & permit;
        wr_en  = '0;
        wr_en[BANK_NS] = acc_wr & permit & ~sec_state;
        wr_en[BANK_S]  = acc_wr & permit & sec_state & ~sec_wr_lock;
    end
endmodule

// File: rtl/sysctl_bank.sv
// One copy of the control register. It stores only the writable bits.
// With SECURE_COPY set, three fields reset from configuration pins, which
// are sampled on every clock edge while rst_n is low.
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter bit SECURE_COPY = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wdata,
    input  logic  cfg_exc_isa,
    input  logic  cfg_exc_be,
    input  logic  cfg_hivec,
    output word_t q
);
    word_t rst_val;

    // pick the reset value for this copy
    generate
        if (SECURE_COPY) begin : g_sec_rst
            always_comb begin
                rst_val           = RST_BASE;
                rst_val[B_EXC_I]  = cfg_exc_isa;
                rst_val[B_EXC_BE] = cfg_exc_be;
                rst_val[B_HIVEC]  = cfg_hivec;
            end
        end else begin : g_ns_rst
            logic unused_cfg;
            assign unused_cfg = cfg_exc_isa ^ cfg_exc_be ^ cfg_hivec;
            assign rst_val = RST_BASE;
        end
    endgenerate

    // storage: synchronous reset, masked write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= rst_val;
        else if (wr_en)
            q <= wdata & WR_MASK;
    end
endmodule

// File: rtl/sysctl_read_view.sv
// Read view: selects the active copy and applies the fixed-bit and
// long-descriptor masks. The read port returns zero unless a permitted
// read is in progress.
module sysctl_read_view
    import sysctl_pkg::*;
(
    input  word_t bank_ns,
    input  word_t bank_s,
    input  logic  sec_state,
    input  logic  long_desc,
    input  logic  rd_ok,
    output word_t view,
    output word_t rdata
);
    word_t sel;

    // masked view of the active copy and the gated read bus
    always_comb begin
        sel   = sec_state ? bank_s : bank_ns;
        view  = (sel & WR_MASK) | FIX1_MASK | (long_desc ? LD_MASK : '0);
        rdata = rd_ok ? view : '0;
    end
endmodule

// File: rtl/sysctl_banked_reg.sv
// Top level of the banked system control register: access control, two
// register copies built by a generate loop, and the read view. Outputs
// follow the active copy combinationally.
module sysctl_banked_reg
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  priv_lvl,
    input  logic        sec_state,
    input  logic        sec_wr_lock,
    input  logic        long_desc,
    input  logic        cfg_exc_isa,
    input  logic        cfg_exc_be,
    input  logic        cfg_hivec,
    output logic [31:0] acc_rdata,
    output logic        acc_fault,
    output logic [31:0] ctl_word,
    output logic        mmu_en,
    output logic        align_chk_en,
    output logic        dcache_en,
    output logic        icache_en
);
    logic [N_BANKS-1:0] wr_en;
    logic               rd_ok;
    word_t              bank_q [N_BANKS];
    word_t              bank_ns_q;
    word_t              bank_s_q;

    sysctl_access_ctl u_acc (
        .acc_rd      (acc_rd),
        .acc_wr      (acc_wr),
        .priv_lvl    (priv_lvl),
        .sec_state   (sec_state),
        .sec_wr_lock (sec_wr_lock),
        .fault       (acc_fault),
        .rd_ok       (rd_ok),
        .wr_en       (wr_en)
    );

    // one storage copy per security state
    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            sysctl_bank #(.SECURE_COPY(b == BANK_S)) u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (wr_en[b]),
                .wdata       (acc_wdata),
                .cfg_exc_isa (cfg_exc_isa),
                .cfg_exc_be  (cfg_exc_be),
                .cfg_hivec   (cfg_hivec),
                .q           (bank_q[b])
            );
        end
    endgenerate

    assign bank_ns_q = bank_q[BANK_NS];
    assign bank_s_q  = bank_q[BANK_S];

    sysctl_read_view u_view (
        .bank_ns   (bank_ns_q),
        .bank_s    (bank_s_q),
        .sec_state (sec_state),
        .long_desc (long_desc),
        .rd_ok     (rd_ok),
        .view      (ctl_word),
        .rdata     (acc_rdata)
    );

    // break out the individually used enables
    always_comb begin
        mmu_en       = ctl_word[B_MMU];
        align_chk_en = ctl_word[B_ALIGN];
        dcache_en    = ctl_word[B_DCACHE];
        icache_en    = ctl_word[B_ICACHE];
    end
endmodule

// File: rtl/sysctl_banked_reg_chk.sv
// Checker for the banked control register, bound to the top module.
// Assumes one strobe per cycle and stable control inputs within a cycle.
module sysctl_banked_reg_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_rd,
    input logic        acc_wr,
    input logic [31:0] acc_wdata,
    input logic [1:0]  priv_lvl,
    input logic        sec_state,
    input logic        sec_wr_lock,
    input logic        long_desc,
    input logic [31:0] acc_rdata,
    input logic        acc_fault,
    input logic [31:0] ctl_word,
    input logic        mmu_en,
    input logic        icache_en,
    input logic [31:0] bank_ns_q,
    input logic [31:0] bank_s_q
);
    // R2
    unpriv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && priv_lvl == 2'd0) |-> (acc_fault && acc_rdata == 32'h0));
    // R2
    unpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && priv_lvl == 2'd0) |=> ($stable(bank_ns_q) && $stable(bank_s_q)));
    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && sec_state && sec_wr_lock) |=> $stable(bank_s_q));
    // R4
    lock_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && priv_lvl != 2'd0 && sec_wr_lock) |-> !acc_fault);
    // R1
    ns_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !sec_state) |=> $stable(bank_s_q));
    // R3
    ns_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !sec_state && priv_lvl != 2'd0) |=>
        ((bank_ns_q & WR_MASK) == ($past(acc_wdata) & WR_MASK)));
    // R5
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_word & FIX1_MASK) == FIX1_MASK) &&
        ((ctl_word & ~(WR_MASK | FIX1_MASK)) == 32'h0));
    // R7
    long_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_desc |-> ((ctl_word & LD_MASK) == LD_MASK));
    // R8
    enable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_en == ctl_word[B_MMU]) && (icache_en == ctl_word[B_ICACHE]));
endmodule

bind sysctl_banked_reg sysctl_banked_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .acc_wdata   (acc_wdata),
    .priv_lvl    (priv_lvl),
    .sec_state   (sec_state),
    .sec_wr_lock (sec_wr_lock),
    .long_desc   (long_desc),
    .acc_rdata   (acc_rdata),
    .acc_fault   (acc_fault),
    .ctl_word    (ctl_word),
    .mmu_en      (mmu_en),
    .icache_en   (icache_en),
    .bank_ns_q   (bank_ns_q),
    .bank_s_q    (bank_s_q)
);

// File: tb/sysctl_banked_reg_test.sv
// Bench: a vector table walked by one loop, then directed reset and output checks.
module sysctl_banked_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_rd, acc_wr;
    logic [31:0] acc_wdata;
    logic [1:0]  priv_lvl;
    logic        sec_state, sec_wr_lock, long_desc;
    logic        cfg_exc_isa, cfg_exc_be, cfg_hivec;
    logic [31:0] acc_rdata, ctl_word;
    logic        acc_fault, mmu_en, align_chk_en, dcache_en, icache_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_banked_reg uut (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .priv_lvl(priv_lvl), .sec_state(sec_state),
        .sec_wr_lock(sec_wr_lock), .long_desc(long_desc),
        .cfg_exc_isa(cfg_exc_isa), .cfg_exc_be(cfg_exc_be), .cfg_hivec(cfg_hivec),
        .acc_rdata(acc_rdata), .acc_fault(acc_fault), .ctl_word(ctl_word),
        .mmu_en(mmu_en), .align_chk_en(align_chk_en), .dcache_en(dcache_en),
        .icache_en(icache_en)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  priv;
        logic        sec;
        logic        lock;
        logic        ld;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_flt;
        logic [7:0]  req;
    } vec_t;

    // one row per cycle; writes check the fault flag only
    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd3},
        '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0,         32'h72DD_39BF, 1'b0, 8'd5},
        '{1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0,         32'h40C5_2838, 1'b0, 8'd1},
        '{1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 32'h0,         32'h0,          1'b0, 8'd4},
        '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0,         32'h40C5_2838, 1'b0, 8'd4},
        '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0005, 32'h0,          1'b0, 8'd3},
        '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0,         32'h00C0_081D, 1'b0, 8'd3},
        '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0,         32'h30C0_081D, 1'b0, 8'd7},
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0,          1'b1, 8'd2},
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0,          1'b1, 8'd2},
        '{1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0,         32'h72DD_39BF, 1'b0, 8'd2},
        '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 8'd1},
        '{1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0,         32'h30C0_0818, 1'b0, 8'd7},
        '{1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 32'h0,         32'h00C0_081D, 1'b0, 8'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_rd = 1'b0; acc_wr = 1'b0; acc_wdata = '0; priv_lvl = 2'd1;
        sec_wr_lock = 1'b0; long_desc = 1'b0;
    endtask

    task automatic do_read(input logic sec, input logic [1:0] pl);
        @(negedge clk);
        idle();
        acc_rd = 1'b1; sec_state = sec; priv_lvl = pl;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        sec_state = 1'b1;
        cfg_exc_isa = 1'b1; cfg_exc_be = 1'b0; cfg_hivec = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // pins flip after reset; the Secure copy must keep its sampled values (R6)
        cfg_exc_isa = 1'b0; cfg_exc_be = 1'b1; cfg_hivec = 1'b0;

        // reset state, both copies (R6)
        do_read(1'b1, 2'd1);
        check("R6 secure reset", acc_rdata, 32'h40C5_2838);
        do_read(1'b0, 2'd1);
        check("R6 non-secure reset", acc_rdata, 32'h00C5_0838);
        @(negedge clk);
        idle();
        #2;
        check("R3 idle read bus", acc_rdata, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acc_wr      = TBL[i].wr;
            acc_rd      = ~TBL[i].wr;
            priv_lvl    = TBL[i].priv;
            sec_state   = TBL[i].sec;
            sec_wr_lock = TBL[i].lock;
            long_desc   = TBL[i].ld;
            acc_wdata   = TBL[i].wd;
            #2;
            check($sformatf("R%0d row %0d fault", TBL[i].req, i),
                  {31'h0, acc_fault}, {31'h0, TBL[i].exp_flt});
            if (!TBL[i].wr)
                check($sformatf("R%0d row %0d rdata", TBL[i].req, i),
                      acc_rdata, TBL[i].exp_rd);
        end

        // enable outputs follow the active copy (R8)
        @(negedge clk);
        idle();
        sec_state = 1'b1;
        #2;
        check("R8 secure ctl_word", ctl_word, 32'h00C0_081D);
        check("R8 secure enables", {28'h0, icache_en, dcache_en, align_chk_en, mmu_en},
              32'h0000_0005);
        sec_state = 1'b0;
        #1;
        check("R8 non-secure enables", {28'h0, icache_en, dcache_en, align_chk_en, mmu_en},
              32'h0);

        // bits 6 and 17 ignore writes; bit 12 lands on icache_en (R5, R8)
        @(negedge clk);
        idle();
        sec_state = 1'b0; acc_wr = 1'b1; acc_wdata = 32'h0002_1042;
        @(negedge clk);
        idle();
        #2;
        check("R5 read-only bits", ctl_word, 32'h00C0_181A);
        check("R8 icache_en", {31'h0, icache_en}, 32'h1);

        // a locked Secure write is dropped and the Non-secure copy is untouched (R1, R4)
        @(negedge clk);
        idle();
        sec_state = 1'b1; sec_wr_lock = 1'b1; acc_wr = 1'b1; acc_wdata = 32'hFFFF_FFFF;
        #2;
        check("R4 lock no fault", {31'h0, acc_fault}, 32'h0);
        do_read(1'b1, 2'd2);
        check("R4 lock kept value", acc_rdata, 32'h00C0_081D);
        do_read(1'b0, 2'd2);
        check("R1 other copy intact", acc_rdata, 32'h00C0_181A);

        @(negedge clk);
        idle();
        finish_run();
    end
endmodule